// File: doc/BRIEF.md
# Spread-Spectrum Chip Despreader with Dual Decision Thresholds

This block turns a serial stream of received spread-spectrum chips back into data bits. Each chip is compared against the matching position of a programmable pseudo-noise reference code, and the block counts how many chips agree. A clean one-bit reproduces the code, so every chip matches. A clean zero-bit arrives as the inverted code, so none match. The code is either 64 or 32 chips long.

At the end of each bit, the match count is compared with two programmable thresholds. A count high enough gives a one and a count low enough gives a zero. A count between the two thresholds gives an erasure. The erasure lets a downstream decoder treat that bit as unknown rather than as a forced guess.

Chips enter on a valid/ready stream. One chip per beat carries a start marker that aligns the bit boundary. Decided bits leave on a second valid/ready stream.

The back-pressure rules are as follows. A chip beat is accepted only on a cycle where both `chip_valid` and `chip_ready` are high. `chip_ready` is low only while a decided bit is held at the output and `bit_ready` is low. A result offered on `bit_valid` stays unchanged until it is accepted.

Top module: `dsss_despreader`

## Requirements
- R1: The code length for a bit is taken from `cfg_len64` on the beat that carries `chip_sob`. A value of 1 selects 64 chips and a value of 0 selects 32 chips. Exactly that many accepted beats, the start beat included, make one bit.
- R2: The n-th accepted chip of a bit (n = 0 on the start beat) counts as a match when it equals `ref_code[n]`. The comparison starts at the least significant code bit. In 32-chip mode, bits 63:32 of the code have no effect.
- R3: When the final match count is greater than or equal to the active high threshold, the bit is delivered with `bit_data`=1 and `bit_erase`=0.
- R4: Otherwise, when the count is less than or equal to the active low threshold, the bit is delivered as `bit_data`=0 and `bit_erase`=0. Any remaining count is delivered as `bit_erase`=1 with `bit_data`=0.
- R5: A one-cycle pulse on `thr_lo_we` or `thr_hi_we` stores `thr_wdata[6:0]` as the low or high threshold. Bit 7 of the write data is ignored. After reset the low threshold is 8 and the high threshold is 56.
- R6: The thresholds and the code length are sampled on the start beat and held for the whole bit. Changes made during a bit affect only later bits.
- R7: A start beat that arrives before the current bit is complete discards the partial bit without any output. Correlation then restarts with that beat as chip 0.
- R8: Accepted chip beats without `chip_sob` while no bit is in progress are ignored and produce no output.
- R9: A decided bit is presented on `bit_valid` one cycle after its last chip is accepted. `bit_valid`, `bit_data` and `bit_erase` stay stable until `bit_ready` is high. `chip_ready` equals NOT `bit_valid` OR `bit_ready`.
- R10: Right after reset, `bit_valid` is low and `chip_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_valid | input | 1 | Chip beat valid |
| chip_ready | output | 1 | Chip beat can be accepted |
| chip_data | input | 1 | Received chip value |
| chip_sob | input | 1 | This beat is the first chip of a bit |
| cfg_len64 | input | 1 | 1 = 64-chip code, 0 = 32-chip code |
| ref_code | input | 64 | Reference pseudo-noise code, LSB first |
| thr_wdata | input | 8 | Threshold write data, bits 6:0 used |
| thr_lo_we | input | 1 | Store write data as the low threshold |
| thr_hi_we | input | 1 | Store write data as the high threshold |
| bit_valid | output | 1 | Decided bit available |
| bit_ready | input | 1 | Downstream accepts the decided bit |
| bit_data | output | 1 | Decided bit value |
| bit_erase | output | 1 | Bit lies between the thresholds |

## Verification
The assertions check the following on every cycle:
- the chip index never passes the end of the selected code;
- the match count never exceeds the number of chips seen;
- a stalled result stays stable;
- `chip_ready` drops only while a result is held;
- an erasure never carries a one.

Some behaviours can only be shown by the bench's scenarios, which compare every delivered bit against counts computed from the injected chip errors:
- the exact threshold boundaries (counts of 56 and 55, 8 and 9);
- the reset threshold values;
- the ignored reserved bit;
- settings changed in the middle of a bit;
- discarded partial bits;
- stray chips that carry no start marker.

// File: rtl/dsss_pkg.sv
package dsss_pkg;
  typedef enum logic [1:0] {
    DEC_ZERO  = 2'd0,
    DEC_ONE   = 2'd1,
    DEC_ERASE = 2'd2
  } dec_e;
endpackage

// File: rtl/dsss_thr_regs.sv
module dsss_thr_regs #(
  parameter int TH_W   = 7,
  parameter int RST_LO = 8,
  parameter int RST_HI = 56
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TH_W-1:0] wdata,
  input  logic            lo_we,
  input  logic            hi_we,
  output logic [TH_W-1:0] thr_lo,
  output logic [TH_W-1:0] thr_hi
);
  localparam int NREG = 2;

  logic [NREG-1:0]            we_vec;
  logic [NREG-1:0][TH_W-1:0]  regs;

  assign we_vec = {hi_we, lo_we};

  // R5: index 0 holds the low threshold, index 1 the high threshold
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [TH_W-1:0] RST_V = (g == 0) ? TH_W'(RST_LO) : TH_W'(RST_HI);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          regs[g] <= RST_V;
      else if (we_vec[g])  regs[g] <= wdata;
    end
  end

  assign thr_lo = regs[0];
  assign thr_hi = regs[1];
endmodule

// File: rtl/dsss_chip_counter.sv
module dsss_chip_counter #(
  parameter int CHIPS_LONG  = 64,
  parameter int CHIPS_SHORT = 32
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  beat,
  input  logic                                  sob,
  input  logic                                  chip,
  input  logic                                  len64,
  input  logic [CHIPS_LONG-1:0]                 code,
  output logic                                  fin_valid,
  output logic [$clog2(CHIPS_LONG+1)-1:0]       fin_count
);
  localparam int CNT_W = $clog2(CHIPS_LONG + 1);
  localparam int IDX_W = $clog2(CHIPS_LONG);

  logic             active;
  logic             long_q;
  logic [IDX_W-1:0] pos;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] sel_idx;
  logic [IDX_W-1:0] last_idx;
  logic             match;
  logic             last;

  // R2: chip n compared against code bit n, LSB first
  assign sel_idx  = sob ? '0 : pos;
  assign match    = (chip == code[sel_idx]);
  assign last_idx = long_q ? IDX_W'(CHIPS_LONG - 1) : IDX_W'(CHIPS_SHORT - 1);
  // R1: a bit completes on its final chip; a start beat never completes one
  assign last      = beat && !sob && active && (pos == last_idx);
  assign fin_valid = last;
  assign fin_count = cnt + CNT_W'(match);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      long_q <= 1'b1;
      pos    <= '0;
      cnt    <= '0;
    end else if (beat && sob) begin
      // R7: restart discards any partial bit
      active <= 1'b1;
      long_q <= len64;
      pos    <= IDX_W'(1);
      cnt    <= CNT_W'(match);
    end else if (beat && active) begin
      if (last) begin
        active <= 1'b0;
      end else begin
        pos <= pos + IDX_W'(1);
        cnt <= cnt + CNT_W'(match);
      end
    end
    // R8: beats without a start marker while idle change nothing
  end

  // R1
  pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (pos <= last_idx));

  // R2
  cnt_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt <= CNT_W'(pos)));
endmodule

// File: rtl/dsss_slicer.sv
module dsss_slicer
  import dsss_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int TH_W  = 7
) (
  input  logic [CNT_W-1:0] count,
  input  logic [TH_W-1:0]  thr_lo,
  input  logic [TH_W-1:0]  thr_hi,
  output dec_e             dec
);
  localparam int CMP_W = (CNT_W > TH_W) ? CNT_W : TH_W;

  logic [CMP_W-1:0] c_ext, lo_ext, hi_ext;

  assign c_ext  = CMP_W'(count);
  assign lo_ext = CMP_W'(thr_lo);
  assign hi_ext = CMP_W'(thr_hi);

  // R3 takes priority over R4 when the thresholds overlap
  always_comb begin
    if (c_ext >= hi_ext)      dec = DEC_ONE;
    else if (c_ext <= lo_ext) dec = DEC_ZERO;
    else                      dec = DEC_ERASE;
  end
endmodule

// File: rtl/dsss_despreader.sv
module dsss_despreader
  import dsss_pkg::*;
#(
  parameter int CHIPS_LONG  = 64,
  parameter int CHIPS_SHORT = 32,
  parameter int TH_W        = 7,
  parameter int REG_W       = 8,
  parameter int RST_LO      = 8,
  parameter int RST_HI      = 56
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  chip_valid,
  output logic                  chip_ready,
  input  logic                  chip_data,
  input  logic                  chip_sob,
  input  logic                  cfg_len64,
  input  logic [CHIPS_LONG-1:0] ref_code,
  input  logic [REG_W-1:0]      thr_wdata,
  input  logic                  thr_lo_we,
  input  logic                  thr_hi_we,
  output logic                  bit_valid,
  input  logic                  bit_ready,
  output logic                  bit_data,
  output logic                  bit_erase
);
  localparam int CNT_W = $clog2(CHIPS_LONG + 1);

  logic             beat;
  logic [TH_W-1:0]  reg_lo, reg_hi;
  logic [TH_W-1:0]  act_lo, act_hi;
  logic             fin_valid;
  logic [CNT_W-1:0] fin_count;
  dec_e             dec;
  logic [REG_W-TH_W-1:0] unused_rsvd;

  // R5: reserved upper bits are dropped
  assign unused_rsvd = thr_wdata[REG_W-1:TH_W];

  // R9
  assign chip_ready = !bit_valid || bit_ready;
  assign beat       = chip_valid && chip_ready;

  dsss_thr_regs #(.TH_W(TH_W), .RST_LO(RST_LO), .RST_HI(RST_HI)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wdata  (thr_wdata[TH_W-1:0]),
    .lo_we  (thr_lo_we),
    .hi_we  (thr_hi_we),
    .thr_lo (reg_lo),
    .thr_hi (reg_hi)
  );

  // R6: thresholds frozen at the start beat
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_lo <= TH_W'(RST_LO);
      act_hi <= TH_W'(RST_HI);
    end else if (beat && chip_sob) begin
      act_lo <= reg_lo;
      act_hi <= reg_hi;
    end
  end

  dsss_chip_counter #(.CHIPS_LONG(CHIPS_LONG), .CHIPS_SHORT(CHIPS_SHORT)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (beat),
    .sob       (chip_sob),
    .chip      (chip_data),
    .len64     (cfg_len64),
    .code      (ref_code),
    .fin_valid (fin_valid),
    .fin_count (fin_count)
  );

  dsss_slicer #(.CNT_W(CNT_W), .TH_W(TH_W)) u_slice (
    .count  (fin_count),
    .thr_lo (act_lo),
    .thr_hi (act_hi),
    .dec    (dec)
  );

  // R9: output holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_valid <= 1'b0;
      bit_data  <= 1'b0;
      bit_erase <= 1'b0;
    end else begin
      if (bit_valid && bit_ready) bit_valid <= 1'b0;
      if (fin_valid) begin
        bit_valid <= 1'b1;
        bit_data  <= (dec == DEC_ONE);
        bit_erase <= (dec == DEC_ERASE);
      end
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !bit_ready) |=> (bit_valid && $stable(bit_data) && $stable(bit_erase)));

  // R9
  ready_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_ready |-> (bit_valid && !bit_ready));

  // R4
  erase_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_erase) |-> !bit_data);
endmodule

// File: tb/test_dsss_despreader.sv
module test_dsss_despreader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chip_valid = 1'b0;
  logic        chip_ready;
  logic        chip_data = 1'b0;
  logic        chip_sob = 1'b0;
  logic        cfg_len64 = 1'b1;
  logic [63:0] ref_code = 64'hA5C3_1F07_9E4B_D268;
  logic [7:0]  thr_wdata = 8'h00;
  logic        thr_lo_we = 1'b0;
  logic        thr_hi_we = 1'b0;
  logic        bit_valid;
  logic        bit_ready = 1'b1;
  logic        bit_data;
  logic        bit_erase;

  int checks = 0;
  int failures = 0;
  int exp_lo = 8;
  int exp_hi = 56;
  int n_out = 0;
  int n_exp = 0;
  int cyc = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #2 clk = ~clk;

  dsss_despreader i_dsss_despreader (
    .clk(clk), .rst_n(rst_n), .chip_valid(chip_valid), .chip_ready(chip_ready),
    .chip_data(chip_data), .chip_sob(chip_sob), .cfg_len64(cfg_len64),
    .ref_code(ref_code), .thr_wdata(thr_wdata), .thr_lo_we(thr_lo_we),
    .thr_hi_we(thr_hi_we), .bit_valid(bit_valid), .bit_ready(bit_ready),
    .bit_data(bit_data), .bit_erase(bit_erase)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected encoding {erase, data}
  function automatic logic [1:0] decide(input int m, input int lo, input int hi);
    if (m >= hi) return 2'b01;
    else if (m <= lo) return 2'b00;
    else return 2'b10;
  endfunction

  task automatic send_chip(input logic c, input logic s);
    @(negedge clk);
    chip_valid = 1'b1;
    chip_data  = c;
    chip_sob   = s;
    #1;
    while (!chip_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    chip_valid = 1'b0;
    chip_sob   = 1'b0;
  endtask

  task automatic wr_thr(input bit hi, input logic [7:0] d);
    @(negedge clk);
    chip_valid = 1'b0;
    thr_wdata  = d;
    thr_lo_we  = !hi;
    thr_hi_we  = hi;
    @(negedge clk);
    thr_lo_we  = 1'b0;
    thr_hi_we  = 1'b0;
  endtask

  // send chips [from, to) of a bit whose data is d, chips 0..nerr-1 inverted
  task automatic send_span(input bit long, input bit d, input int nerr, input int from, input int to);
    for (int i = from; i < to; i++) begin
      logic c;
      c = d ? ref_code[i] : ~ref_code[i];
      if (i < nerr) c = ~c;
      if (i == 0) cfg_len64 = long;
      send_chip(c, i == 0);
    end
  endtask

  task automatic push_exp(input bit long, input bit d, input int nerr, input int lo, input int hi, input string tag);
    int len;
    int m;
    len = long ? 64 : 32;
    m = d ? len - nerr : nerr;
    exp_q.push_back(decide(m, lo, hi));
    tag_q.push_back(tag);
    n_exp++;
  endtask

  task automatic send_bit(input bit long, input bit d, input int nerr, input string tag);
    push_exp(long, d, nerr, exp_lo, exp_hi, tag);
    send_span(long, d, nerr, 0, long ? 64 : 32);
  endtask

  // ready pattern changes just after each rising edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    bit_ready = (cyc % 7 != 3) && (cyc % 11 != 5);
  end

  // monitor / scoreboard
  logic       prev_stall = 1'b0;
  logic [1:0] prev_val = 2'b00;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_stall)
        check(bit_valid && {bit_erase, bit_data} == prev_val, "R9 held-output",
              {bit_valid, bit_erase, bit_data}, {1'b1, prev_val});
      prev_stall = bit_valid && !bit_ready;
      prev_val   = {bit_erase, bit_data};
      if (bit_valid && bit_ready) begin
        n_out++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7/R8 unexpected-output", n_out, n_exp);
        end else begin
          logic [1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({bit_erase, bit_data} == e, t, {bit_erase, bit_data}, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R10: reset state
    check(bit_valid == 1'b0, "R10 bit_valid", bit_valid, 0);
    check(chip_ready == 1'b1, "R10 chip_ready", chip_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5 reset thresholds, R3 boundary 56, R4 boundaries
    send_bit(1, 1, 0, "R3 perfect-one-64");
    send_bit(1, 1, 8, "R3 R5 count56-hi-reset");
    send_bit(1, 1, 9, "R4 count55-erase");
    send_bit(1, 0, 0, "R4 perfect-zero-64");
    send_bit(1, 0, 8, "R4 R5 count8-lo-reset");
    send_bit(1, 0, 9, "R4 count9-erase");
    idle();

    // R8: stray chips with no start marker
    for (int i = 0; i < 5; i++) send_chip(1'b1, 1'b0);
    idle();

    // R5: reserved bit ignored (0x9C -> 28, 0x84 -> 4)
    wr_thr(1, 8'h9C);
    wr_thr(0, 8'h84);
    exp_hi = 28; exp_lo = 4;
    // R1 32-chip mode, R2 upper code half unused
    ref_code[63:32] = ~ref_code[63:32];
    send_bit(0, 1, 0, "R1 R2 perfect-one-32");
    send_bit(0, 1, 4, "R1 R5 count28-one");
    send_bit(0, 1, 5, "R1 count27-erase");
    send_bit(0, 0, 4, "R1 R4 count4-zero");
    send_bit(0, 0, 5, "R1 count5-erase");

    // R7: partial bit aborted by a new start beat
    send_span(1, 1, 0, 0, 10);
    send_bit(0, 0, 0, "R7 restart-after-partial");
    send_span(0, 1, 0, 0, 31);
    send_bit(1, 1, 3, "R7 restart-one-short");
    idle();

    // R6: settings changed in mid-bit apply to later bits only
    wr_thr(1, 8'h38);
    wr_thr(0, 8'h08);
    exp_hi = 56; exp_lo = 8;
    push_exp(1, 1, 9, 8, 56, "R6 midbit-change-old-used");
    send_span(1, 1, 9, 0, 20);
    wr_thr(1, 8'h10);
    wr_thr(0, 8'h02);
    cfg_len64 = 1'b0;
    send_span(1, 1, 9, 20, 64);
    exp_hi = 16; exp_lo = 2;
    send_bit(0, 1, 16, "R6 new-thr-after-boundary");
    send_bit(0, 0, 3, "R6 new-lo-erase");

    // mixed batch
    wr_thr(1, 8'h38);
    wr_thr(0, 8'h08);
    exp_hi = 56; exp_lo = 8;
    for (int k = 0; k < 24; k++) begin
      bit l;
      bit d;
      int e;
      l = (k % 3) != 0;
      d = k[0];
      e = $urandom_range(0, 14);
      if (!l) begin
        if (d) begin
          push_exp(0, d, e, exp_lo, exp_hi, "R3 batch-32");
          send_span(0, d, e, 0, 32);
        end else begin
          send_bit(0, d, e, "R4 batch-32");
        end
      end else begin
        send_bit(1, d, e, d ? "R3 batch-64" : "R4 batch-64");
      end
    end
    idle();

    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R9 all-delivered", exp_q.size(), 0);
    check(n_out == n_exp, "R7 R8 output-count", n_out, n_exp);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule